// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block produces the interrupt flags of a synchronous serial port that has an 8-entry receive FIFO and an 8-entry transmit FIFO. The FIFOs and the shift engine sit outside the block. The block sees their occupancy counts, a one-cycle pulse for each completed received frame, and a one-cycle pulse for each read of the receive FIFO. From these it derives four raw conditions:

- a receive overrun;
- a receive timeout, which means unread data has been left waiting;
- a receive FIFO that is at least half full;
- a transmit FIFO that has at least half of its entries free.

A software-writable enable register gates the raw conditions into a masked status. The interrupt line is the OR of the masked status bits. The overrun and timeout flags are sticky and are cleared through a write-only clear register. The timeout is measured in serial bit times. One bit time is the product of the prescale divisor and the rate value plus one, counted in clock cycles. When a frame arrives into a full receive FIFO, the block tells the FIFO to overwrite its newest entry with the incoming frame.

Top module: `spi_irq_status`

## Requirements
- R1: The register map is selected by `reg_addr`. Address 0 is the enable mask (read/write). Address 1 is raw status (read-only). Address 2 is masked status (read-only). Address 3 is clear (write-only, reads 0). In every status, mask and clear word: bit 0 is overrun, bit 1 is timeout, bit 2 is receive half full, and bit 3 is transmit half empty. Bits 31:4 read 0. Writes to addresses 1 and 2 change nothing.
- R2: The enable mask resets to 0. It takes bits 3:0 of a write to address 0 at the clock edge, and it ignores write bits 31:4.
- R3: Masked status equals raw status AND mask. `irq` is 1 exactly when any masked status bit is 1.
- R4: A `frame_done` pulse while `rx_level` is 8 drives `rx_replace` high in that same cycle, and it sets the sticky overrun bit from the next clock edge. A frame that arrives at any lower level does neither.
- R5: While the receive FIFO is non-empty, with no read and no new frame, the sticky timeout bit becomes 1 exactly 32 × D × (S+1) clock edges after the last restart. D is `clk_prescale`, with 0 treated as 1, and S is `serial_rate`. One edge earlier it still reads 0.
- R6: The timeout measurement restarts on an `rx_pop` pulse or a `frame_done` pulse. While the receive FIFO is empty it is held at zero, so the timeout is never raised.
- R7: Raw bit 2 is 1 exactly when `rx_level` is at least 4.
- R8: Raw bit 3 is 1 exactly when 8 − `tx_level` is at least 4.
- R9: Writing address 3 clears the overrun bit where data bit 0 is 1, and the timeout bit where data bit 1 is 1. Bits written as 0 leave the flags unchanged. A set condition in the same cycle as a clear wins.
- R10: After reset, with an empty transmit FIFO and an empty receive FIFO, raw status reads 0x8, the mask reads 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 4 | Receive FIFO occupancy, 0 to 8 |
| tx_level | input | 4 | Transmit FIFO occupancy, 0 to 8 |
| frame_done | input | 1 | One-cycle pulse per completed received frame |
| rx_pop | input | 1 | One-cycle pulse per receive FIFO read |
| clk_prescale | input | 8 | Prescale divisor D (0 acts as 1) |
| serial_rate | input | 8 | Rate value S; bit time is D×(S+1) clocks |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| rx_replace | output | 1 | Overwrite the newest receive entry with the incoming frame |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the occupancy inputs never exceed 8. They also assume that `frame_done` and `rx_pop` are single-cycle pulses, and that a pop is never reported while the receive FIFO is empty. The stimulus changes levels and pulses only at falling edges and keeps every level inside 0 to 8. It holds the receive level constant during each timeout window, so the counted window depends only on the restart events being exercised. The divisor and rate are set to very large values whenever a test must not see a timeout.

// File: rtl/spi_irq_status.sv
`timescale 1ns/1ps
module spi_irq_status #(
  parameter int DEPTH        = 8,
  parameter int DATA_W       = 32,
  parameter int TIMEOUT_BITS = 32,
  parameter int DIV_W        = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(DEPTH+1)-1:0]       rx_level,
  input  logic [$clog2(DEPTH+1)-1:0]       tx_level,
  input  logic                             frame_done,
  input  logic                             rx_pop,
  input  logic [DIV_W-1:0]                 clk_prescale,
  input  logic [DIV_W-1:0]                 serial_rate,
  input  logic [1:0]                       reg_addr,
  input  logic                             reg_wr,
  input  logic [DATA_W-1:0]                reg_wdata,
  output logic [DATA_W-1:0]                reg_rdata,
  output logic                             rx_replace,
  output logic                             irq
);
  localparam int LVL_W = $clog2(DEPTH+1);
  localparam int HALF  = DEPTH / 2;
  localparam int BL_W  = 2 * DIV_W + 1;
  localparam int BC_W  = $clog2(TIMEOUT_BITS + 1);
  localparam logic [1:0] A_MASK = 2'd0;
  localparam logic [1:0] A_RAW  = 2'd1;
  localparam logic [1:0] A_MSK  = 2'd2;

  logic [3:0]      mask_q;
  logic            ovr_q, tmo_q;
  logic [BL_W-1:0] cyc_q;
  logic [BC_W-1:0] bits_q;

  wire [BL_W-1:0] div_eff = (clk_prescale == '0) ? BL_W'(1) : BL_W'(clk_prescale);
  wire [BL_W-1:0] bit_len = div_eff * (BL_W'(serial_rate) + BL_W'(1));
  wire            tick    = (cyc_q >= bit_len - BL_W'(1));
  wire            rx_full = (rx_level == LVL_W'(DEPTH));
  wire            restart = rx_pop | frame_done | (rx_level == '0);
  wire            ovr_hit = frame_done & rx_full;
  wire            tmo_hit = ~restart & tick & (bits_q == BC_W'(TIMEOUT_BITS - 1));
  wire            clr_wr  = reg_wr & (reg_addr == 2'd3);
  wire            rx_half = (rx_level >= LVL_W'(HALF));
  wire            tx_half = ((LVL_W'(DEPTH) - tx_level) >= LVL_W'(HALF));
  wire [3:0]      raw     = {tx_half, rx_half, tmo_q, ovr_q};
  wire [3:0]      masked  = raw & mask_q;

  assign rx_replace = ovr_hit;
  assign irq        = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      bits_q <= '0;
    end else if (restart) begin
      cyc_q  <= '0;
      bits_q <= '0;
    end else if (tick) begin
      cyc_q  <= '0;
      if (bits_q < BC_W'(TIMEOUT_BITS)) bits_q <= bits_q + BC_W'(1);
    end else begin
      cyc_q  <= cyc_q + BL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      if (ovr_hit) ovr_q <= 1'b1;
      else if (clr_wr && reg_wdata[0]) ovr_q <= 1'b0;
      if (tmo_hit) tmo_q <= 1'b1;
      else if (clr_wr && reg_wdata[1]) tmo_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MASK:  reg_rdata = {{(DATA_W-4){1'b0}}, mask_q};
      A_RAW:   reg_rdata = {{(DATA_W-4){1'b0}}, raw};
      A_MSK:   reg_rdata = {{(DATA_W-4){1'b0}}, masked};
      default: reg_rdata = '0;
    endcase
  end

  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_level == LVL_W'(DEPTH)) |=> ovr_q);

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_MASK) |=> $stable(mask_q));

  // R6
  tmo_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> ($past(rx_level) != '0 && !$past(rx_pop) && !$past(frame_done)));

  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 4'd0));

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> ovr_q);

  // R9
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !(reg_wr && reg_addr == 2'd3 && reg_wdata[1])) |=> tmo_q);
endmodule

// File: tb/sim_spi_irq_status.sv
`timescale 1ns/1ps
module sim_spi_irq_status;
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rx_level = '0, tx_level = '0;
  logic        frame_done = 1'b0, rx_pop = 1'b0;
  logic [7:0]  clk_prescale = 8'd255, serial_rate = 8'd255;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_replace, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];

  always #10 clk = ~clk;

  spi_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .frame_done(frame_done), .rx_pop(rx_pop), .clk_prescale(clk_prescale),
    .serial_rate(serial_rate), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_replace(rx_replace), .irq(irq)
  );

  // monitor: compares queued expectations in the low phase, after the driver settles
  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = reg_rdata;
          1: act = {31'd0, irq};
          default: act = {31'd0, rx_replace};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    reg_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_now(input int kind, input logic e, input string tag);
    item_t it;
    it.kind = kind; it.exp = {31'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  // checks timeout edge: 'len' edges per bit after a restart pulse
  task automatic tmo_window(input int len, input string tag);
    pop();
    repeat (32*len - 2) @(negedge clk);
    rd(2'd1, {28'd0, 1'b0, rx_level >= 4, 1'b0, 1'b0} | {28'd0, (8 - tx_level) >= 4, 3'b0}, {tag, " one edge early"});
    rd(2'd1, {28'd0, (8 - tx_level) >= 4, rx_level >= 4, 1'b1, 1'b0}, {tag, " at window"});
    wr(2'd3, 32'h2);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd1, 32'h8, "R10 raw after reset");
    rd(2'd0, 32'h0, "R10 mask after reset");
    expect_now(1, 1'b0, "R10 irq after reset");
    rd(2'd3, 32'h0, "R1 clear reads zero");

    wr(2'd0, 32'hFFFF_FFF5);
    rd(2'd0, 32'h5, "R2 mask write, reserved ignored");
    wr(2'd1, 32'hF);
    rd(2'd1, 32'h8, "R1 raw read-only");
    rd(2'd2, 32'h0, "R3 masked with tx bit disabled");
    expect_now(1, 1'b0, "R3 irq low");
    wr(2'd0, 32'hF);
    rd(2'd2, 32'h8, "R3 masked tx bit");
    expect_now(1, 1'b1, "R3 irq high");

    @(negedge clk); tx_level = 4'd5;
    rd(2'd1, 32'h0, "R8 tx free 3");
    @(negedge clk); tx_level = 4'd4;
    rd(2'd1, 32'h8, "R8 tx free 4");
    @(negedge clk); tx_level = 4'd8;
    rd(2'd1, 32'h0, "R8 tx full");
    @(negedge clk); rx_level = 4'd3;
    rd(2'd1, 32'h0, "R7 rx 3");
    @(negedge clk); rx_level = 4'd4;
    rd(2'd1, 32'h4, "R7 rx 4");

    @(negedge clk); rx_level = 4'd7; frame_done = 1'b1;
    expect_now(2, 1'b0, "R4 no replace below full");
    @(negedge clk); frame_done = 1'b0;
    rd(2'd1, 32'h4, "R4 no overrun below full");
    @(negedge clk); rx_level = 4'd8; frame_done = 1'b1;
    expect_now(2, 1'b1, "R4 replace when full");
    @(negedge clk); frame_done = 1'b0;
    rd(2'd1, 32'h5, "R4 overrun set");
    wr(2'd0, 32'h1);
    expect_now(1, 1'b1, "R3 irq from overrun");
    wr(2'd3, 32'h2);
    rd(2'd1, 32'h5, "R9 clearing other bit keeps overrun");
    wr(2'd3, 32'h1);
    rd(2'd1, 32'h4, "R9 overrun cleared");
    expect_now(1, 1'b0, "R9 irq drops after clear");
    @(negedge clk);
    reg_addr = 2'd3; reg_wdata = 32'h1; reg_wr = 1'b1; frame_done = 1'b1;
    @(negedge clk); reg_wr = 1'b0; frame_done = 1'b0;
    rd(2'd1, 32'h5, "R9 set wins over clear");
    wr(2'd3, 32'h1);

    @(negedge clk); rx_level = 4'd1; tx_level = 4'd0;
    clk_prescale = 8'd2; serial_rate = 8'd1;
    tmo_window(4, "R5 D=2 S=1");
    @(negedge clk); clk_prescale = 8'd1; serial_rate = 8'd0;
    tmo_window(1, "R5 D=1 S=0");
    @(negedge clk); clk_prescale = 8'd0; serial_rate = 8'd0;
    tmo_window(1, "R5 D=0 acts as 1");

    @(negedge clk); clk_prescale = 8'd2; serial_rate = 8'd1;
    pop();
    repeat (100) @(negedge clk);
    frame();
    repeat (126) @(negedge clk);
    rd(2'd1, 32'h8, "R6 frame restarts window, early");
    rd(2'd1, 32'hA, "R6 frame restarts window, at window");
    wr(2'd3, 32'h2);
    pop();
    repeat (60) @(negedge clk);
    pop();
    repeat (100) @(negedge clk);
    rd(2'd1, 32'h8, "R6 pop restarts window");
    @(negedge clk); rx_level = 4'd0;
    repeat (300) @(negedge clk);
    rd(2'd1, 32'h8, "R6 empty fifo never times out");
    wr(2'd0, 32'h2);
    @(negedge clk); rx_level = 4'd2;
    repeat (130) @(negedge clk);
    rd(2'd2, 32'h2, "R3 masked timeout");
    expect_now(1, 1'b1, "R3 irq from timeout");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule